// File: doc/BRIEF.md
# Serial Mux Sample-Hold Command Receiver

This block takes a short serial command stream, sent by a timer or sequencer elsewhere in the controller, and turns it into logic-level controls. The controls drive three sample-and-hold channels and one 4-bit analog multiplexer select. The stream has its own command clock and data line. Both lines are resynchronised to the system clock, and every command bit is taken on a rising edge of the command clock, most significant bit first. An 8-bit frame carries one unused leading bit, three hold bits and a 4-bit select.

Each field is applied at its own point inside the frame. The hold controls change on the falling edge of the fourth command clock. The mux select changes on the falling edge of the eighth command clock, so the holds always settle before the select moves. A second path writes the same 7-bit word directly from a configuration register. That path is honoured only while the stream enable is low. Lowering the enable also returns the frame receiver to its idle state.

Top module: `mux_hold_cmd_rx`

## Requirements
- R1: After a synchronous active-low reset, hold_o reads 3'b000 (all channels sampling) and mux_sel_o reads 4'b0000.
- R2: A command clock falling edge that completes a field takes effect at the third rising system-clock edge after the input transition. At the second rising edge the output still shows its old value.
- R3: Command bits are captured on rising command-clock edges, most significant frame bit first: frame bit 7 is sent first and frame bit 0 last.
- R4: The hold fields come from frame bits 6..4, with hold_o[2]=bit 6, hold_o[1]=bit 5 and hold_o[0]=bit 4. A value of 0 means sample and 1 means hold.
- R5: hold_o takes its new value on the fourth falling command-clock edge of a frame. mux_sel_o is not changed at that point.
- R6: mux_sel_o takes frame bits 3..0 (bit 3 as the MSB) on the eighth falling command-clock edge of a frame.
- R7: Frame bit 7 has no effect on either output.
- R8: The frame counter wraps after eight command clocks, so a frame that follows directly is decoded from its own first bit.
- R9: While stream_en_i is low, command-clock activity has no effect on the outputs, and any partly received frame is discarded. The next frame after re-enabling is decoded from its first bit.
- R10: While stream_en_i is low, a reg_wr_i pulse loads reg_wdata_i[6:4] into hold_o and reg_wdata_i[3:0] into mux_sel_o on the next clock edge.
- R11: While stream_en_i is high, reg_wr_i is ignored, including in the cycle where a stream field is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_clk_i | input | 1 | Serial command clock, asynchronous to clk |
| cmd_dat_i | input | 1 | Serial command data, sampled on rising cmd_clk_i |
| stream_en_i | input | 1 | Serial path enable; low clears the receiver and hands control to register writes |
| reg_wr_i | input | 1 | Direct register write strobe |
| reg_wdata_i | input | 7 | Direct write word: [6:4] hold, [3:0] mux select |
| hold_o | output | 3 | Sample-and-hold controls, 1 = hold |
| mux_sel_o | output | 4 | Analog multiplexer select |

## Verification
A register write and a stream field load can land in the same system-clock cycle. The bench provokes this by raising reg_wr_i, with a word that differs from the frame, exactly in the cycle after the second rising edge that follows the fourth command-clock fall. In that cycle the synchronised edge is being acted on. The hold outputs must then show the frame's bits and not the register word, and the later select must also follow the frame. A scoreboard holds the ordered list of output values expected from the stream and the register paths, and any unexpected output change counts as a failure.

// File: rtl/mhc_pkg.sv
// Package: shared field widths and the 7-bit command word layout.
// Assumes the serial frame and the direct register use the same field order.
package mhc_pkg;
    localparam int HOLD_W = 3;
    localparam int MUX_W  = 4;
    localparam int CMD_W  = HOLD_W + MUX_W;

    // Command word: hold controls above the mux select.
    typedef struct packed {
        logic [HOLD_W-1:0] hold;
        logic [MUX_W-1:0]  mux;
    } mhc_word_t;
endpackage

// File: rtl/mhc_sync.sv
// Module: multi-stage synchroniser for one asynchronous input.
// Assumes STAGES >= 1; the output lags the input by STAGES clk edges.
module mhc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= d_i;
            end
        end else begin : g_chain
            // Shift the input through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/mhc_frame_rx.sv
// Module: frame receiver. It detects edges of the synchronised command clock,
// shifts in data on rising edges and flags the hold and mux load points on falling edges.
// Assumes the command clock idles low; only the last MUX_W bits need storage.
module mhc_frame_rx
    import mhc_pkg::*;
#(
    parameter int FRAME_BITS = 8,
    parameter int HOLD_POINT = 4,
    parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             sclk_i,
    input  logic             sdat_i,
    output logic             hold_ld_o,
    output logic             mux_ld_o,
    output logic [MUX_W-1:0] shift_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] HOLD_CNT = CNT_W'(HOLD_POINT);

    logic             sclk_q;
    logic             rise, fall;
    logic [MUX_W-1:0] shift_q;
    logic [CNT_W-1:0] cnt_q;

    assign rise = sclk_i & ~sclk_q;
    assign fall = ~sclk_i & sclk_q;

    // Previous synchronised clock level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_i;
    end

    // Bit counter and shift register; cleared while the stream is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (rise) begin
            shift_q <= {shift_q[MUX_W-2:0], sdat_i};
            cnt_q   <= cnt_q + 1'b1;
        end else if (fall && cnt_q == LAST_CNT) begin
            cnt_q   <= '0;
        end
    end

    assign hold_ld_o = en_i & fall & (cnt_q == HOLD_CNT);
    assign mux_ld_o  = en_i & fall & (cnt_q == LAST_CNT);
    assign shift_o   = shift_q;
    assign cnt_o     = cnt_q;
endmodule

// File: rtl/mhc_field_regs.sv
// Module: output field registers. The stream loads win while enabled;
// register writes are taken only while the stream is disabled.
// Assumes the load strobes come from mhc_frame_rx.
module mhc_field_regs
    import mhc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              hold_ld_i,
    input  logic              mux_ld_i,
    input  logic [MUX_W-1:0]  shift_i,
    input  logic              reg_wr_i,
    input  logic [CMD_W-1:0]  reg_wdata_i,
    output logic [HOLD_W-1:0] hold_o,
    output logic [MUX_W-1:0]  mux_o
);
    mhc_word_t wr_word;
    assign wr_word = mhc_word_t'(reg_wdata_i);

    // Select the source for each field according to the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_o <= '0;
            mux_o  <= '0;
        end else if (en_i) begin
            if (hold_ld_i) hold_o <= shift_i[HOLD_W-1:0];
            if (mux_ld_i)  mux_o  <= shift_i;
        end else if (reg_wr_i) begin
            hold_o <= wr_word.hold;
            mux_o  <= wr_word.mux;
        end
    end
endmodule

// File: rtl/mux_hold_cmd_rx.sv
// Module: top of the serial mux / sample-hold command receiver.
// Assumes cmd_clk_i and cmd_dat_i are asynchronous and change slowly compared with clk.
module mux_hold_cmd_rx
    import mhc_pkg::*;
#(
    parameter int FRAME_BITS  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_clk_i,
    input  logic              cmd_dat_i,
    input  logic              stream_en_i,
    input  logic              reg_wr_i,
    input  logic [CMD_W-1:0]  reg_wdata_i,
    output logic [HOLD_W-1:0] hold_o,
    output logic [MUX_W-1:0]  mux_sel_o
);
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int HOLD_POINT = FRAME_BITS / 2;

    logic             sclk_s, sdat_s;
    logic             hold_ld, mux_ld;
    logic [MUX_W-1:0] frame_q;
    logic [CNT_W-1:0] bit_cnt;

    mhc_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .d_i(cmd_clk_i), .q_o(sclk_s)
    );
    mhc_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .d_i(cmd_dat_i), .q_o(sdat_s)
    );

    mhc_frame_rx #(
        .FRAME_BITS(FRAME_BITS), .HOLD_POINT(HOLD_POINT), .CNT_W(CNT_W)
    ) u_frame (
        .clk(clk), .rst_n(rst_n), .en_i(stream_en_i),
        .sclk_i(sclk_s), .sdat_i(sdat_s),
        .hold_ld_o(hold_ld), .mux_ld_o(mux_ld),
        .shift_o(frame_q), .cnt_o(bit_cnt)
    );

    mhc_field_regs u_fields (
        .clk(clk), .rst_n(rst_n), .en_i(stream_en_i),
        .hold_ld_i(hold_ld), .mux_ld_i(mux_ld), .shift_i(frame_q),
        .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
        .hold_o(hold_o), .mux_o(mux_sel_o)
    );
endmodule

// File: rtl/mhc_rx_chk.sv
// Module: assertion checker bound to mux_hold_cmd_rx.
// Assumes access to the internal load strobes, shift register and counter.
module mhc_rx_chk
    import mhc_pkg::*;
#(
    parameter int FRAME_BITS = 8,
    parameter int CNT_W      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stream_en_i,
    input logic              reg_wr_i,
    input logic [CMD_W-1:0]  reg_wdata_i,
    input logic [HOLD_W-1:0] hold_o,
    input logic [MUX_W-1:0]  mux_sel_o,
    input logic              hold_ld,
    input logic              mux_ld,
    input logic [MUX_W-1:0]  frame_q,
    input logic [CNT_W-1:0]  bit_cnt
);
    // R10: register write in disabled mode loads both fields
    a_r10_reg_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!stream_en_i && reg_wr_i) |=>
            (hold_o == $past(reg_wdata_i[CMD_W-1:MUX_W]) && mux_sel_o == $past(reg_wdata_i[MUX_W-1:0])));

    // R11 / R5: while streaming, hold moves only on a hold load
    a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_en_i && !hold_ld) |=> $stable(hold_o));

    // R11 / R6: while streaming, mux moves only on a mux load
    a_r11_mux_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_en_i && !mux_ld) |=> $stable(mux_sel_o));

    // R5 R6: the two load points never coincide
    a_r5_r6_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_ld && mux_ld));

    // R6: mux takes the last shifted nibble
    a_r6_mux_load: assert property (@(posedge clk) disable iff (!rst_n)
        mux_ld |=> (mux_sel_o == $past(frame_q)));

    // R9: disabling clears the frame counter
    a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !stream_en_i |=> (bit_cnt == '0));

    // R8: counter never passes the frame length
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_BITS));
endmodule

bind mux_hold_cmd_rx mhc_rx_chk #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .stream_en_i(stream_en_i),
    .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .hold_o(hold_o), .mux_sel_o(mux_sel_o),
    .hold_ld(hold_ld), .mux_ld(mux_ld), .frame_q(frame_q), .bit_cnt(bit_cnt)
);

// File: tb/mux_hold_cmd_rx_tb_top.sv
// Scoreboard bench: the driver tasks push expected output words; a monitor
// pops and compares each time the outputs change.
module mux_hold_cmd_rx_tb_top;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_clk = 1'b0, cmd_dat = 1'b0, en = 1'b0;
    logic       reg_wr = 1'b0;
    logic [6:0] reg_wdata = '0;
    logic [2:0] hold;
    logic [3:0] mux;

    int total = 0, bad = 0;
    logic [6:0] exp_q[$];
    int         tag_q[$];
    logic [6:0] model = '0;
    logic [6:0] last_seen = '0;
    int         mcnt = 0;
    logic [3:0] mshift = '0;
    logic       probe = 1'b0, collide = 1'b0;
    logic [6:0] collide_word = '0;
    logic       done = 1'b0;

    always #2 clk = ~clk;

    mux_hold_cmd_rx dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_clk_i(cmd_clk), .cmd_dat_i(cmd_dat),
        .stream_en_i(en), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
        .hold_o(hold), .mux_sel_o(mux)
    );

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic push(input logic [6:0] w, input int tag);
        if (w != model) begin
            exp_q.push_back(w);
            tag_q.push_back(tag);
            model = w;
        end
    endtask

    // Monitor: every output change must match the next expected word.
    always @(negedge clk) begin
        if (rst_n && !done && {hold, mux} !== last_seen) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R11 unexpected change act=%b exp=%b", {hold, mux}, last_seen);
            end else begin
                automatic logic [6:0] e = exp_q.pop_front();
                automatic int t = tag_q.pop_front();
                if ({hold, mux} !== e) begin
                    bad++;
                    $display("FAIL R%0d scoreboard act=%b exp=%b", t, {hold, mux}, e);
                end
            end
            last_seen = {hold, mux};
        end
    end

    // One command bit: data set, rise, fall, with model update.
    task automatic cmd_bit(input logic b);
        @(negedge clk);
        cmd_dat = b;
        repeat (HALF) @(negedge clk);
        cmd_clk = 1'b1;
        if (en) begin
            mshift = {mshift[2:0], b};
            mcnt++;
        end
        repeat (HALF) @(negedge clk);
        if (en && mcnt == 4) push({mshift[2:0], model[3:0]}, 5);
        if (en && mcnt == 8) begin
            push({model[6:4], mshift}, 6);
            mcnt = 0;
        end
        cmd_clk = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (probe && mcnt == 4)
            check("R2 hold before third edge", {4'b0, hold}, {4'b0, last_seen[6:4]});
        if (collide && mcnt == 4) begin
            reg_wr = 1'b1;
            reg_wdata = collide_word;
        end
        @(negedge clk);
        reg_wr = 1'b0;
        if (probe && mcnt == 4) begin
            check("R2 R5 hold at third edge", {4'b0, hold}, {4'b0, mshift[2:0]});
            check("R5 mux unchanged at hold point", {3'b0, mux}, {3'b0, model[3:0]});
        end
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] f);
        for (int i = 7; i >= 0; i--) cmd_bit(f[i]);
    endtask

    task automatic set_en(input logic v);
        @(negedge clk);
        en = v;
        mcnt = 0;
        mshift = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic reg_write(input logic [6:0] w);
        @(negedge clk);
        if (!en) push(w, 10);
        reg_wr = 1'b1;
        reg_wdata = w;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", {hold, mux}, 7'b000_0000);

        reg_write(7'b101_1010);
        check("R10 register load", {hold, mux}, 7'b101_1010);

        set_en(1'b1);
        reg_write(7'b010_0101);
        check("R11 write ignored while enabled", {hold, mux}, 7'b101_1010);

        probe = 1'b1;
        send_frame(8'b1_011_0110);
        probe = 1'b0;
        check("R3 R4 R6 frame decode", {hold, mux}, 7'b011_0110);

        send_frame(8'b1_000_0000);
        check("R7 leading bit ignored", {hold, mux}, 7'b000_0000);

        send_frame(8'b0_111_1111);
        send_frame(8'b0_010_0011);
        check("R8 back to back frames", {hold, mux}, 7'b010_0011);

        collide = 1'b1;
        collide_word = 7'b111_1000;
        send_frame(8'b0_100_0101);
        collide = 1'b0;
        check("R11 write in load cycle ignored", {hold, mux}, 7'b100_0101);

        cmd_bit(1'b1); cmd_bit(1'b1); cmd_bit(1'b1);
        set_en(1'b0);
        send_frame(8'b0_110_1110);
        check("R9 stream ignored while disabled", {hold, mux}, 7'b100_0101);
        set_en(1'b1);
        send_frame(8'b0_001_1100);
        check("R9 fresh frame after re-enable", {hold, mux}, 7'b001_1100);

        set_en(1'b0);
        reg_write(7'b110_0011);
        check("R10 register load after streaming", {hold, mux}, 7'b110_0011);

        repeat (4) @(negedge clk);
        check("R4 R6 scoreboard drained", 7'(exp_q.size()), 7'd0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R1 watchdog act=%b exp=%b", 1'b1, 1'b0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule